// File: doc/BRIEF.md
# Page Walk Permission Checker

This block sits beside a page-table walker and decides whether a memory access may proceed. The walker first hands over the request: the virtual address, the access kind (read, write or instruction fetch), the privilege, and the control bits. These are the write-protect enable, the no-execute enable, physical address extension (PAE) and long mode. The walker then streams one beat per table entry it reads. Each beat carries that entry's present, reserved-violation, no-execute, user, writable and dirty bits. It also carries a flag marking the pointer-table level and a flag marking the final entry.

The checker merges the permissions level by level. It stops at the first entry that is not present or that breaks a reserved-bit rule. At the final entry it returns a verdict: either the read/write/execute rights a TLB may cache, or a page-fault error code. On every fault it also records the faulting virtual address.

All three data paths use valid/ready handshakes. A request is taken only while `req_ready` is high, and that happens only when the block is idle. Entry beats are taken only while `lvl_ready` is high, which holds from the cycle after request acceptance until the walk ends. The response stays valid and does not change while `rsp_ready` is low. No new request is accepted until the response has been consumed.

Top module: `pgperm_check`

## Requirements
- R1: Handshakes. `req_ready` is high only when idle, `lvl_ready` only during a walk, and the two are never high together or while `rsp_valid` is high. A response held back by `rsp_ready` low keeps its valid, verdict, rights and code unchanged.
- R2: The effective user and writable rights are the AND of those bits over all merged levels.
- R3: With PAE on, the effective no-execute is set when any merged level has no-execute set, and execute is then withheld. With PAE off, the no-execute inputs are ignored.
- R4: With PAE on and long mode off, a beat flagged as pointer level imposes no user, writable or no-execute restriction.
- R5: A fetch (kind 2'd2) whose effective no-execute is set is a protection fault.
- R6: A user access faults without the effective user right. A user write (kind 2'd1) also faults without the effective writable right.
- R7: A supervisor write to a non-writable page faults only when `req_wp` is 1. With `req_wp` 0 it is allowed.
- R8: A beat with present clear ends the walk with a fault whose code bit 0 is clear.
- R9: A reserved fault sets code bit 3 and ends the walk. It is raised by `lvl_rsvd`, or with PAE on and `req_nxe` 0 by a set no-execute bit on any level except a legacy-PAE pointer level.
- R10: In a fault code, bit 0 marks a protection violation, bit 1 a write and bit 2 a user access. Bit 4 is set only for a fetch with both `req_nxe` and `req_pae` at 1. A successful response has code 0.
- R11: `fault_addr` takes the request's virtual address when a fault response is produced, and is otherwise unchanged. It resets to 0.
- R12: `rsp_perm` is {execute, write, read} in bits 2..0. On success read is always granted, and execute is granted exactly when the effective no-execute is clear. On a fault `rsp_perm` is 0.
- R13: Write is granted only when the final entry's dirty bit is 1 and the writable rule allows it. For a user access the rule is the effective writable bit. For a supervisor access it is `req_wp` 0 or the effective writable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with valid |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| req_user | input | 1 | User privilege access |
| req_wp | input | 1 | Supervisor write protection enable |
| req_nxe | input | 1 | No-execute enable |
| req_pae | input | 1 | Physical address extension mode |
| req_lma | input | 1 | Long mode active |
| lvl_valid | input | 1 | Entry beat offered |
| lvl_ready | output | 1 | Entry beat accepted when high with valid |
| lvl_present | input | 1 | Entry present bit |
| lvl_rsvd | input | 1 | Walker found a reserved-bit violation |
| lvl_nx | input | 1 | Entry no-execute bit |
| lvl_user | input | 1 | Entry user bit |
| lvl_rw | input | 1 | Entry writable bit |
| lvl_dirty | input | 1 | Entry dirty bit (used on the final entry) |
| lvl_ptr | input | 1 | Entry is the pointer-table level |
| lvl_last | input | 1 | Entry is the final translation entry |
| rsp_valid | output | 1 | Verdict available |
| rsp_ready | input | 1 | Verdict consumed when high with valid |
| rsp_ok | output | 1 | Access allowed |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_code | output | 5 | Page-fault error code |
| fault_addr | output | VA_W | Last faulting virtual address |

## Verification
Request acceptance takes one edge, and `lvl_ready` rises in the cycle after it. The verdict, rights, code and `fault_addr` are all registered on the edge that accepts the ending beat, so they are valid one cycle after that beat. The bench drives on falling edges and waits for each ready before advancing. It samples every result at the falling edge right after the ending beat is taken, while `rsp_ready` is held low, so all results are read in exactly the cycle they first appear. The back-pressure scenario holds `rsp_ready` low for several more cycles and checks that the response stays unchanged.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  localparam int ERR_W    = 5;
  localparam int EB_PROT  = 0;
  localparam int EB_WRITE = 1;
  localparam int EB_USER  = 2;
  localparam int EB_RSVD  = 3;
  localparam int EB_FETCH = 4;

  localparam int PERM_W = 3;
  localparam int PB_R   = 0;
  localparam int PB_W   = 1;
  localparam int PB_X   = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSV   = 2'd3
  } acc_kind_e;

  // nnx is the inverted no-execute bit, so merging is a plain AND
  typedef struct packed {
    logic user;
    logic rw;
    logic nnx;
  } perm_t;

  typedef struct packed {
    logic is_write;
    logic is_fetch;
    logic user;
    logic wp;
    logic nxe;
    logic pae;
    logic lma;
  } req_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } state_e;
endpackage

// File: rtl/pgperm_accum.sv
module pgperm_accum
  import pgperm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  input  logic  pae,
  input  logic  lma,
  input  logic  ent_ptr,
  input  logic  ent_nx,
  input  logic  ent_user,
  input  logic  ent_rw,
  output perm_t merged
);
  perm_t acc_q;
  perm_t contrib;
  logic  neutral;

  always_comb begin
    neutral      = pae && !lma && ent_ptr;
    contrib.user = ent_user | neutral;
    contrib.rw   = ent_rw | neutral;
    contrib.nnx  = ~(ent_nx & pae) | neutral;
    merged       = perm_t'(acc_q & contrib);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '1;
    else if (clear)  acc_q <= '1;
    else if (step)   acc_q <= merged;
  end
endmodule

// File: rtl/pgperm_judge.sv
module pgperm_judge
  import pgperm_pkg::*;
(
  input  perm_t             eff,
  input  logic              dirty,
  input  logic              is_write,
  input  logic              is_fetch,
  input  logic              is_user,
  input  logic              wp,
  output logic              prot_fault,
  output logic [PERM_W-1:0] grant
);
  logic eff_nx, nx_viol, usr_viol, sup_viol, wr_ok;

  always_comb begin
    eff_nx     = ~eff.nnx;
    nx_viol    = is_fetch & eff_nx;
    usr_viol   = is_user & (~eff.user | (is_write & ~eff.rw));
    sup_viol   = ~is_user & wp & is_write & ~eff.rw;
    prot_fault = nx_viol | usr_viol | sup_viol;
    wr_ok      = is_user ? eff.rw : (~wp | eff.rw);
    grant        = '0;
    grant[PB_R]  = 1'b1;
    grant[PB_W]  = dirty & wr_ok;
    grant[PB_X]  = ~eff_nx;
    if (prot_fault) grant = '0;
  end
endmodule

// File: rtl/pgperm_errcode.sv
module pgperm_errcode
  import pgperm_pkg::*;
(
  input  logic             prot,
  input  logic             rsvd,
  input  logic             is_write,
  input  logic             is_user,
  input  logic             is_fetch,
  input  logic             nxe,
  input  logic             pae,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    code           = '0;
    code[EB_PROT]  = prot;
    code[EB_WRITE] = is_write;
    code[EB_USER]  = is_user;
    code[EB_RSVD]  = rsvd;
    code[EB_FETCH] = is_fetch & nxe & pae;
  end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
  import pgperm_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic            req_user,
  input  logic            req_wp,
  input  logic            req_nxe,
  input  logic            req_pae,
  input  logic            req_lma,
  input  logic            lvl_valid,
  output logic            lvl_ready,
  input  logic            lvl_present,
  input  logic            lvl_rsvd,
  input  logic            lvl_nx,
  input  logic            lvl_user,
  input  logic            lvl_rw,
  input  logic            lvl_dirty,
  input  logic            lvl_ptr,
  input  logic            lvl_last,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_ok,
  output logic [2:0]      rsp_perm,
  output logic [4:0]      rsp_code,
  output logic [VA_W-1:0] fault_addr
);
  state_e            state_q;
  req_ctl_t          ctl_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              ok_q;
  logic [PERM_W-1:0] perm_q;
  logic [ERR_W-1:0]  code_q;
  logic [VA_W-1:0]   faddr_q;

  logic req_fire, lvl_fire, rsp_fire;
  logic not_present, legacy_ptr, rsvd_hit, walk_done, prot_hit, fault;
  perm_t             merged;
  logic              prot_raw;
  logic [PERM_W-1:0] grant;
  logic [ERR_W-1:0]  code_n;

  assign req_ready = (state_q == ST_IDLE);
  assign lvl_ready = (state_q == ST_WALK);
  assign rsp_valid = (state_q == ST_RESP);
  assign req_fire  = req_valid & req_ready;
  assign lvl_fire  = lvl_valid & lvl_ready;
  assign rsp_fire  = rsp_valid & rsp_ready;

  always_comb begin
    not_present = ~lvl_present;
    legacy_ptr  = lvl_ptr & ~ctl_q.lma;
    rsvd_hit    = lvl_present &
                  (lvl_rsvd | (ctl_q.pae & ~ctl_q.nxe & lvl_nx & ~legacy_ptr));
    walk_done   = not_present | rsvd_hit | lvl_last;
    prot_hit    = lvl_last & ~not_present & ~rsvd_hit & prot_raw;
    fault       = not_present | rsvd_hit | prot_hit;
  end

  pgperm_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (req_fire),
    .step     (lvl_fire & ~walk_done),
    .pae      (ctl_q.pae),
    .lma      (ctl_q.lma),
    .ent_ptr  (lvl_ptr),
    .ent_nx   (lvl_nx),
    .ent_user (lvl_user),
    .ent_rw   (lvl_rw),
    .merged   (merged)
  );

  pgperm_judge u_judge (
    .eff        (merged),
    .dirty      (lvl_dirty),
    .is_write   (ctl_q.is_write),
    .is_fetch   (ctl_q.is_fetch),
    .is_user    (ctl_q.user),
    .wp         (ctl_q.wp),
    .prot_fault (prot_raw),
    .grant      (grant)
  );

  pgperm_errcode u_errcode (
    .prot     (prot_hit),
    .rsvd     (rsvd_hit),
    .is_write (ctl_q.is_write),
    .is_user  (ctl_q.user),
    .is_fetch (ctl_q.is_fetch),
    .nxe      (ctl_q.nxe),
    .pae      (ctl_q.pae),
    .code     (code_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      vaddr_q <= '0;
      ok_q    <= 1'b0;
      perm_q  <= '0;
      code_q  <= '0;
      faddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          ctl_q.is_write <= (req_kind == ACC_WRITE);
          ctl_q.is_fetch <= (req_kind == ACC_FETCH);
          ctl_q.user     <= req_user;
          ctl_q.wp       <= req_wp;
          ctl_q.nxe      <= req_nxe;
          ctl_q.pae      <= req_pae;
          ctl_q.lma      <= req_lma;
          vaddr_q        <= req_vaddr;
          state_q        <= ST_WALK;
        end
        ST_WALK: if (lvl_fire && walk_done) begin
          ok_q    <= ~fault;
          perm_q  <= fault ? '0 : grant;
          code_q  <= fault ? code_n : '0;
          if (fault) faddr_q <= vaddr_q;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_ok     = ok_q;
  assign rsp_perm   = perm_q;
  assign rsp_code   = code_q;
  assign fault_addr = faddr_q;
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva #(
  parameter int VA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            lvl_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_ok,
  input logic [2:0]      rsp_perm,
  input logic [4:0]      rsp_code,
  input logic [VA_W-1:0] fault_addr
);
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_perm) && $stable(rsp_code)); // R1
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && lvl_ready) && !(rsp_valid && (req_ready || lvl_ready))); // R1
  AST_OK_GRANTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> rsp_perm[0] && (rsp_code == 5'd0)); // R12
  AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> (rsp_perm == 3'd0)); // R12
  AST_RSVD_NOT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code[3] |-> !rsp_code[0]); // R9
  AST_FETCH_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code[4] |-> !rsp_code[1]); // R10
  AST_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> rsp_valid && !rsp_ok); // R11
endmodule

bind pgperm_check pgperm_check_sva #(.VA_W(VA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .lvl_ready  (lvl_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_ok     (rsp_ok),
  .rsp_perm   (rsp_perm),
  .rsp_code   (rsp_code),
  .fault_addr (fault_addr)
);

// File: tb/pgperm_check_bench.sv
`timescale 1ns/1ps
module pgperm_check_bench;
  localparam int VA_W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_user = 0, req_wp = 0, req_nxe = 0, req_pae = 0, req_lma = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = 2'd0;
  logic lvl_valid = 0, lvl_present = 0, lvl_rsvd = 0, lvl_nx = 0, lvl_user = 0;
  logic lvl_rw = 0, lvl_dirty = 0, lvl_ptr = 0, lvl_last = 0;
  logic rsp_ready = 0;
  logic req_ready, lvl_ready, rsp_valid, rsp_ok;
  logic [2:0] rsp_perm;
  logic [4:0] rsp_code;
  logic [VA_W-1:0] fault_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgperm_check #(.VA_W(VA_W)) u_pgperm_check (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .req_wp(req_wp),
    .req_nxe(req_nxe), .req_pae(req_pae), .req_lma(req_lma),
    .lvl_valid(lvl_valid), .lvl_ready(lvl_ready), .lvl_present(lvl_present),
    .lvl_rsvd(lvl_rsvd), .lvl_nx(lvl_nx), .lvl_user(lvl_user), .lvl_rw(lvl_rw),
    .lvl_dirty(lvl_dirty), .lvl_ptr(lvl_ptr), .lvl_last(lvl_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_perm(rsp_perm), .rsp_code(rsp_code), .fault_addr(fault_addr)
  );

  // entry byte: {present, rsvd, nx, user, rw, dirty, ptr, last}
  function automatic logic [7:0] ent(input bit p, rs, nx, u, rw, d, ptr, last);
    return {p, rs, nx, u, rw, d, ptr, last};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Drives a request and n entry beats; returns at the falling edge where the verdict is due.
  task automatic walk(input logic [VA_W-1:0] va, input logic [1:0] kind,
                      input bit u, wp, nxe, pae, lma, input int n, input logic [31:0] lv);
    req_vaddr = va; req_kind = kind; req_user = u; req_wp = wp;
    req_nxe = nxe; req_pae = pae; req_lma = lma; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin
      {lvl_present, lvl_rsvd, lvl_nx, lvl_user, lvl_rw, lvl_dirty, lvl_ptr, lvl_last} = lv[i*8 +: 8];
      lvl_valid = 1;
      while (!lvl_ready) @(negedge clk);
      @(negedge clk);
    end
    lvl_valid = 0;
  endtask

  task automatic verdict(input string rq, input bit ok, input logic [2:0] perm, input logic [4:0] code);
    chk({rq, " rsp_valid"}, rsp_valid, 1);
    chk({rq, " rsp_ok"}, rsp_ok, ok);
    chk({rq, " rsp_perm"}, rsp_perm, perm);
    chk({rq, " rsp_code"}, rsp_code, code);
  endtask

  task automatic consume();
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  localparam logic [7:0] MID  = 8'b1001_1100; // present user rw dirty
  localparam logic [7:0] LAST = 8'b1001_1101;

  task automatic t_reset();
    chk("R1 reset req_ready", req_ready, 1);
    chk("R1 reset lvl_ready", lvl_ready, 0);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    chk("R11 reset fault_addr", fault_addr, 0);
  endtask

  task automatic t_basic();
    walk(48'h1000, 2'd0, 1, 0, 1, 1, 1, 4, {LAST, MID, MID, MID});
    verdict("R2 R12 R13 all-permissive user read", 1, 3'b111, 5'd0);
    chk("R1 lvl_ready low during response", lvl_ready, 0);
    chk("R1 req_ready low during response", req_ready, 0);
    consume();
  endtask

  task automatic t_user_and();
    walk(48'h2345, 2'd0, 1, 0, 1, 1, 1, 4,
         {LAST, MID, ent(1,0,0,0,1,1,0,0), MID});
    verdict("R2 R6 user bit cleared mid-walk", 0, 3'b000, 5'd5);
    chk("R11 fault_addr captured", fault_addr, 48'h2345);
    consume();
    walk(48'h3000, 2'd1, 1, 0, 1, 1, 1, 3,
         {LAST, ent(1,0,0,1,0,1,0,0), MID});
    verdict("R2 R6 user write read-only level", 0, 3'b000, 5'd7);
    consume();
  endtask

  task automatic t_nx();
    walk(48'h4000, 2'd2, 0, 0, 1, 1, 1, 4,
         {LAST, MID, ent(1,0,1,1,1,1,0,0), MID});
    verdict("R3 R5 R10 fetch with nx on one level", 0, 3'b000, 5'd17);
    consume();
    walk(48'h4100, 2'd0, 0, 0, 1, 1, 1, 4,
         {LAST, ent(1,0,1,1,1,1,0,0), MID, MID});
    verdict("R3 R12 read of nx page withholds exec", 1, 3'b011, 5'd0);
    consume();
    walk(48'h4200, 2'd2, 0, 0, 0, 0, 0, 2,
         {16'h0, ent(1,0,1,1,1,0,0,1), ent(1,0,1,1,1,1,0,0)});
    verdict("R3 R13 nx ignored without PAE, clean page", 1, 3'b101, 5'd0);
    consume();
  endtask

  task automatic t_legacy_ptr();
    walk(48'h5000, 2'd1, 1, 1, 1, 1, 0, 3,
         {LAST, MID, ent(1,0,1,0,0,0,1,0)});
    verdict("R4 pointer level is permissive", 1, 3'b111, 5'd0);
    consume();
  endtask

  task automatic t_wp();
    walk(48'h6000, 2'd1, 0, 0, 1, 1, 1, 2,
         {16'h0, ent(1,0,0,1,0,1,0,1), MID});
    verdict("R7 R13 supervisor write wp=0", 1, 3'b111, 5'd0);
    consume();
    walk(48'h6100, 2'd1, 0, 1, 1, 1, 1, 2,
         {16'h0, ent(1,0,0,1,0,1,0,1), MID});
    verdict("R7 supervisor write wp=1", 0, 3'b000, 5'd3);
    chk("R11 fault_addr on wp fault", fault_addr, 48'h6100);
    consume();
  endtask

  task automatic t_not_present();
    walk(48'h7000, 2'd1, 1, 0, 1, 1, 1, 2,
         {16'h0, ent(0,0,0,1,1,1,0,0), MID});
    verdict("R8 R10 not present at level 2", 0, 3'b000, 5'd6);
    chk("R1 walk ended lvl_ready", lvl_ready, 0);
    consume();
  endtask

  task automatic t_rsvd();
    walk(48'h8000, 2'd0, 0, 0, 0, 1, 1, 1, {24'h0, ent(1,0,1,1,1,1,0,0)});
    verdict("R9 nx with nxe clear", 0, 3'b000, 5'd8);
    consume();
    walk(48'h8100, 2'd2, 0, 0, 1, 1, 1, 2, {16'h0, ent(1,1,0,1,1,1,0,0), MID});
    verdict("R9 R10 walker reserved flag on fetch", 0, 3'b000, 5'd24);
    chk("R11 fault_addr on reserved", fault_addr, 48'h8100);
    consume();
  endtask

  task automatic t_dirty();
    walk(48'h9000, 2'd1, 1, 0, 1, 1, 1, 2, {16'h0, ent(1,0,0,1,1,0,0,1), MID});
    verdict("R13 clean page no write grant", 1, 3'b101, 5'd0);
    chk("R11 fault_addr kept on success", fault_addr, 48'h8100);
    consume();
  endtask

  task automatic t_backpressure();
    walk(48'hA000, 2'd0, 1, 0, 1, 1, 1, 1, {24'h0, ent(1,0,0,0,1,1,0,1)});
    verdict("R1 first cycle of stalled fault", 0, 3'b000, 5'd5);
    repeat (3) @(negedge clk);
    verdict("R1 held after stall", 0, 3'b000, 5'd5);
    chk("R1 req_ready low while stalled", req_ready, 0);
    consume();
    chk("R1 idle after consume", req_ready, 1);
    chk("R1 rsp_valid dropped", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_user_and();
    t_nx();
    t_legacy_ptr();
    t_wp();
    t_not_present();
    t_rsvd();
    t_dirty();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule